// File: doc/BRIEF.md
# Serial port register block

A byte-wide register file for a simple asynchronous serial port. It sits behind a plain CPU bus with a 16-bit address, a write strobe, write data and combinational read data. It holds six 8-bit registers in the 0xFE page: mode, bit-rate, control, transmit data, status and receive data. The status flags are hardware-owned. Software can clear a flag by writing 0 to it, but can never set one.

Transmit-empty recovery is modelled as a delay counted in ticks. Every transmit-data write restarts the delay. `tick_i` is a one-cycle enable that advances it. A transmit-data write made while the transmit enable is on also presents the byte on a valid/data output. The same byte is collected into a fixed-length frame, and each full frame is compared with a parameterised heartbeat pattern. A match raises a sticky flag.

A receive strobe loads the receive-data register and marks it full. The bit-level serializer, the baud divider and interrupt generation live elsewhere.

Top module: `serial_port_regs`

## Requirements
- R1: The block decodes an address only when `addr_i[15:8]` is 0xFE. Within that page the offsets are mode 0xD8, bit-rate 0xD9, control 0xDA, transmit data 0xDB, status 0xDC and receive data 0xDD. A read of any other address returns 0x00 and changes no state.
- R2: The mode and bit-rate registers are plain read/write storage.
- R3: The control register reads back what was written. Bit 5 is the transmit enable (TE).
- R4: After reset the registers read: mode 0x00, bit-rate 0xFF, control 0x0C, transmit data 0xFF, status 0x87, receive data 0x00.
- R5: A status write works per flag bit. Each of bits 7..3 becomes its old value ANDed with the written bit, so writing 1 never sets a flag. Bits 2..0 take the written value. Bit 7 is transmit-empty (TDRE), bit 6 is receive-full (RDRF) and bit 5 is overrun.
- R6: A transmit-data write always updates that register. When TE was 1 at the write, `tx_valid_o` is high for the next cycle only, with `tx_data_o` equal to the byte. Otherwise `tx_valid_o` stays low.
- R7: Every transmit-data write loads the ready delay with READY_TICKS (default 2) and arms a pending flag. A tick that falls in the same cycle as the write has no effect on the delay.
- R8: A tick first decrements a nonzero delay while pending is armed. If the delay is then 0 and TDRE is 0, TDRE is set and pending is cleared. If TDRE is already 1, pending stays armed until a later tick finds TDRE cleared.
- R9: Only bytes emitted under R6 fill a frame of HB_LEN bytes. When a frame is full it is compared with HB_PATTERN and then emptied. The first byte of the frame is compared with bits [7:0] of the pattern. The default pattern bytes, in order, are 3C C3 AA 55. `hb_seen_o` rises the cycle after a matching frame completes and stays high until reset.
- R10: A receive strobe loads `rx_data_i` into the receive-data register and sets RDRF. The bus can also write the receive-data register, but a strobe in the same cycle wins.
- R11: A receive strobe that arrives while RDRF is 1 sets the overrun flag.
- R12: When a hardware event and a bus status write fall in the same cycle, the bus write is applied first and the hardware sets then act on the result. A tick that expires the delay sets TDRE even if the same write cleared it. A receive strobe sets RDRF even if the same write cleared it. In that case no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| we_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| tick_i | input | 1 | One-cycle ready-delay tick enable |
| rx_valid_i | input | 1 | Receive byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Emitted transmit byte valid, one cycle |
| tx_data_o | output | 8 | Emitted transmit byte |
| hb_seen_o | output | 1 | Sticky heartbeat-frame match |

## Verification
The contested state is the status register. A software clear and a hardware set can land on the same flag in the same cycle: a status write with a tick that expires the ready delay, or a status write with a receive strobe. The bench drives those pairs together in one cycle. It also drives a transmit-data write together with a tick, and a receive-data bus write together with a receive strobe. Each outcome is judged against the ordering of R12, both in directed readbacks and by a behavioural model compared on every clock.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam logic [7:0] PAGE     = 8'hFE;
  localparam logic [7:0] OFF_MODE = 8'hD8;
  localparam logic [7:0] OFF_BAUD = 8'hD9;
  localparam logic [7:0] OFF_CTRL = 8'hDA;
  localparam logic [7:0] OFF_TXD  = 8'hDB;
  localparam logic [7:0] OFF_STAT = 8'hDC;
  localparam logic [7:0] OFF_RXD  = 8'hDD;

  localparam int CTRL_TE   = 5;
  localparam int STAT_TDRE = 7;
  localparam int STAT_RDRF = 6;
  localparam int STAT_OVR  = 5;
  localparam logic [7:0] FLAG_MASK = 8'hF8;

  localparam logic [7:0] RST_MODE = 8'h00;
  localparam logic [7:0] RST_BAUD = 8'hFF;
  localparam logic [7:0] RST_CTRL = 8'h0C;
  localparam logic [7:0] RST_TXD  = 8'hFF;
  localparam logic [7:0] RST_STAT = 8'h87;
  localparam logic [7:0] RST_RXD  = 8'h00;
endpackage

// File: rtl/sp_ready_timer.sv
module sp_ready_timer #(
  parameter int READY_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  input  logic tdre_i,
  output logic set_tdre_o
);
  localparam int CNT_W = (READY_TICKS < 2) ? 1 : $clog2(READY_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             pend_q;

  always_comb begin
    cnt_dec    = (pend_q && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    set_tdre_o = tick_i && !load_i && pend_q && (cnt_dec == '0) && !tdre_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CNT_W'(READY_TICKS);
      pend_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_dec;
      if (set_tdre_o) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_frame_match.sv
module sp_frame_match #(
  parameter int              HB_LEN     = 4,
  parameter logic [HB_LEN*8-1:0] HB_PATTERN = 32'h55AA_C33C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       emit_i,
  input  logic [7:0] byte_i,
  output logic       hb_seen_o
);
  localparam int IDX_W = (HB_LEN < 2) ? 1 : $clog2(HB_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(HB_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       buf_q [HB_LEN-1];
  logic [HB_LEN-1:0] eq;
  logic             last;

  assign last  = (idx_q == LAST);
  assign eq[HB_LEN-1] = (byte_i == HB_PATTERN[(HB_LEN-1)*8 +: 8]);

  for (genvar i = 0; i < HB_LEN - 1; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              buf_q[i] <= '0;
      else if (emit_i && idx_q == IDX_W'(i))    buf_q[i] <= byte_i;
    end
    assign eq[i] = (buf_q[i] == HB_PATTERN[i*8 +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      hb_seen_o <= 1'b0;
    end else if (emit_i) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (last && &eq) hb_seen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int              READY_TICKS = 2,
  parameter int              HB_LEN      = 4,
  parameter logic [HB_LEN*8-1:0] HB_PATTERN = 32'h55AA_C33C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        tick_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        hb_seen_o
);
  logic [7:0] mode_q, baud_q, ctrl_q, txd_q, status_q, rdr_q;
  logic [7:0] st_w, st_n;
  logic       in_page, wr, wr_txd, wr_stat, emit, set_tdre;
  logic [7:0] off;

  assign in_page = (addr_i[15:8] == PAGE);
  assign off     = addr_i[7:0];
  assign wr      = we_i && in_page;
  assign wr_txd  = wr && off == OFF_TXD;
  assign wr_stat = wr && off == OFF_STAT;
  assign emit    = wr_txd && ctrl_q[CTRL_TE];

  sp_ready_timer #(.READY_TICKS(READY_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_txd),
    .tick_i     (tick_i),
    .tdre_i     (st_w[STAT_TDRE]),
    .set_tdre_o (set_tdre)
  );

  sp_frame_match #(.HB_LEN(HB_LEN), .HB_PATTERN(HB_PATTERN)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .emit_i    (emit),
    .byte_i    (wdata_i),
    .hb_seen_o (hb_seen_o)
  );

  // bus write first, hardware sets on top of it
  always_comb begin
    st_w = wr_stat ? ((status_q & wdata_i & FLAG_MASK) | (wdata_i & ~FLAG_MASK)) : status_q;
    st_n = st_w;
    if (rx_valid_i) begin
      st_n[STAT_OVR]  = st_w[STAT_OVR] | st_w[STAT_RDRF];
      st_n[STAT_RDRF] = 1'b1;
    end
    if (set_tdre) st_n[STAT_TDRE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= RST_MODE;
      baud_q     <= RST_BAUD;
      ctrl_q     <= RST_CTRL;
      txd_q      <= RST_TXD;
      status_q   <= RST_STAT;
      rdr_q      <= RST_RXD;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      status_q   <= st_n;
      tx_valid_o <= emit;
      if (emit) tx_data_o <= wdata_i;
      if (wr && off == OFF_MODE) mode_q <= wdata_i;
      if (wr && off == OFF_BAUD) baud_q <= wdata_i;
      if (wr && off == OFF_CTRL) ctrl_q <= wdata_i;
      if (wr_txd)                txd_q  <= wdata_i;
      if (rx_valid_i)                 rdr_q <= rx_data_i;
      else if (wr && off == OFF_RXD)  rdr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_page) begin
      unique case (off)
        OFF_MODE: rdata_o = mode_q;
        OFF_BAUD: rdata_o = baud_q;
        OFF_CTRL: rdata_o = ctrl_q;
        OFF_TXD:  rdata_o = txd_q;
        OFF_STAT: rdata_o = status_q;
        OFF_RXD:  rdata_o = rdr_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sp_regs_chk.sv
module sp_regs_chk
  import serial_port_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        we_i,
  input logic [7:0]  wdata_i,
  input logic        tick_i,
  input logic        rx_valid_i,
  input logic [7:0]  rx_data_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o,
  input logic        hb_seen_o,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  status_q,
  input logic [7:0]  rdr_q
);
  logic wr_txd, wr_stat;
  assign wr_txd  = we_i && addr_i == {PAGE, OFF_TXD};
  assign wr_stat = we_i && addr_i == {PAGE, OFF_STAT};

  // R6
  tx_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(wr_txd && ctrl_q[CTRL_TE]));

  // R6
  tx_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd && ctrl_q[CTRL_TE]) |=> (tx_valid_o && tx_data_o == $past(wdata_i)));

  // R9
  hb_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_seen_o |=> hb_seen_o);

  // R10
  rx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rdr_q == $past(rx_data_i) && status_q[STAT_RDRF]));

  // R11
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && status_q[STAT_RDRF] && !wr_stat) |=> status_q[STAT_OVR]);

  // R5
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[7:3] == 5'd0 && !rx_valid_i && !tick_i) |=> status_q[7:3] == 5'd0);
endmodule

bind serial_port_regs sp_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .tick_i     (tick_i),
  .rx_valid_i (rx_valid_i),
  .rx_data_i  (rx_data_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .hb_seen_o  (hb_seen_o),
  .ctrl_q     (ctrl_q),
  .status_q   (status_q),
  .rdr_q      (rdr_q)
);

// File: tb/tb_serial_port_regs.sv
module tb_serial_port_regs;
  localparam int RT = 2;
  localparam int HL = 4;
  localparam logic [31:0] PAT = 32'h55AA_C33C;

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 16'h0000;
  logic we = 0, tick = 0, rxv = 0;
  logic [7:0] wdata = 0, rxd = 0;
  logic [7:0] rdata, txd;
  logic txv, hb;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  serial_port_regs #(.READY_TICKS(RT), .HB_LEN(HL), .HB_PATTERN(PAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .rx_valid_i(rxv), .rx_data_i(rxd),
    .tx_valid_o(txv), .tx_data_o(txd), .hb_seen_o(hb));

  // behavioural reference
  int m_mode, m_baud, m_ctrl, m_txd, m_st, m_rdr, m_dly, m_txdat;
  bit m_pend, m_txv, m_hb;
  int m_frame[$];

  function automatic int m_read(input logic [15:0] a);
    if (a[15:8] != 8'hFE) return 0;
    case (a[7:0])
      8'hD8: return m_mode;
      8'hD9: return m_baud;
      8'hDA: return m_ctrl;
      8'hDB: return m_txd;
      8'hDC: return m_st;
      8'hDD: return m_rdr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_baud = 'hFF; m_ctrl = 'h0C; m_txd = 'hFF; m_st = 'h87; m_rdr = 0;
      m_dly = 0; m_pend = 0; m_txv = 0; m_hb = 0; m_txdat = 0; m_frame.delete();
    end else begin
      bit wr, twr;
      int wd;
      wd = int'(wdata);
      wr = we && addr[15:8] == 8'hFE;
      twr = wr && addr[7:0] == 8'hDB;
      m_txv = 0;
      if (wr) begin
        case (addr[7:0])
          8'hD8: m_mode = wd;
          8'hD9: m_baud = wd;
          8'hDA: m_ctrl = wd;
          8'hDB: begin
            m_txd = wd;
            if ((m_ctrl & 'h20) != 0) begin
              m_txv = 1; m_txdat = wd;
              m_frame.push_back(wd);
              if (m_frame.size() == HL) begin
                bit ok;
                ok = 1;
                for (int i = 0; i < HL; i++)
                  if (m_frame[i] != int'(PAT[i*8 +: 8])) ok = 0;
                if (ok) m_hb = 1;
                m_frame.delete();
              end
            end
            m_dly = RT; m_pend = 1;
          end
          8'hDC: m_st = (m_st & wd & 'hF8) | (wd & 'h07);
          8'hDD: m_rdr = wd;
          default: ;
        endcase
      end
      if (rxv) begin
        if ((m_st & 'h40) != 0) m_st = m_st | 'h20;
        m_st = m_st | 'h40;
        m_rdr = int'(rxd);
      end
      if (tick && !twr) begin
        if (m_pend && m_dly > 0) m_dly = m_dly - 1;
        if (m_pend && m_dly == 0 && (m_st & 'h80) == 0) begin
          m_st = m_st | 'h80; m_pend = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'hFED8, 16'hFED9: return "R2 rdata";
      16'hFEDA: return "R3 rdata";
      16'hFEDB: return "R6 rdata";
      16'hFEDC: return "R5 rdata";
      16'hFEDD: return "R10 rdata";
      default:  return "R1 rdata";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(tag_of(addr), int'(rdata), m_read(addr));
      chk("R6 tx_valid", int'(txv), int'(m_txv));
      if (m_txv) chk("R6 tx_data", int'(txd), m_txdat);
      chk("R9 hb_seen", int'(hb), int'(m_hb));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one bus cycle, optional simultaneous tick/rx
  task automatic cyc_drv(input bit w, input logic [7:0] off, input logic [7:0] d,
                         input bit t, input bit r, input logic [7:0] rd);
    @(negedge clk);
    we = w; addr = {8'hFE, off}; wdata = d; tick = t; rxv = r; rxd = rd;
    @(negedge clk);
    we = 0; tick = 0; rxv = 0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    cyc_drv(1, off, d, 0, 0, 0);
  endtask

  task automatic tk();
    cyc_drv(0, 8'h00, 0, 1, 0, 0);
  endtask

  task automatic rx(input logic [7:0] d);
    cyc_drv(0, 8'h00, 0, 0, 1, d);
  endtask

  task automatic rd(input logic [15:0] a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    #2;
    chk(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset values
    rd(16'hFED8, 'h00, "R4 mode");
    rd(16'hFED9, 'hFF, "R4 baud");
    rd(16'hFEDA, 'h0C, "R4 ctrl");
    rd(16'hFEDB, 'hFF, "R4 txd");
    rd(16'hFEDC, 'h87, "R4 status");
    rd(16'hFEDD, 'h00, "R4 rxd");
    // R1 unmapped
    rd(16'hFEDE, 'h00, "R1 unmapped");
    rd(16'h12DA, 'h00, "R1 other page");
    // R2
    wr(8'hD8, 8'hA5); rd(16'hFED8, 'hA5, "R2 mode");
    wr(8'hD9, 8'h33); rd(16'hFED9, 'h33, "R2 baud");
    // R6 TE off
    wr(8'hDB, 8'h11);
    chk("R6 no emit TE=0", int'(txv), 0);
    rd(16'hFEDB, 'h11, "R6 txd stored");
    // R3
    wr(8'hDA, 8'hF0); rd(16'hFEDA, 'hF0, "R3 ctrl");
    wr(8'hDA, 8'h20);
    // R5 clear TDRE
    wr(8'hDC, 8'h7F); rd(16'hFEDC, 'h07, "R5 clear");
    // R8 delay expiry
    tk(); rd(16'hFEDC, 'h07, "R8 tick1");
    tk(); rd(16'hFEDC, 'h87, "R8 tick2");
    // R9 wrong frame then right frame with a TE-off byte inside
    wr(8'hDB, 8'h3C);
    chk("R6 emit valid", int'(txv), 1);
    chk("R6 emit data", int'(txd), 'h3C);
    wr(8'hDB, 8'hC3); wr(8'hDB, 8'h00); wr(8'hDB, 8'h11);
    chk("R9 no match", int'(hb), 0);
    wr(8'hDB, 8'h3C); wr(8'hDB, 8'hC3);
    wr(8'hDA, 8'h00); wr(8'hDB, 8'hAA); wr(8'hDA, 8'h20);
    wr(8'hDB, 8'hAA);
    chk("R9 not yet", int'(hb), 0);
    wr(8'hDB, 8'h55);
    chk("R9 match", int'(hb), 1);
    // R8 pending held while TDRE=1
    repeat (5) tk();
    rd(16'hFEDC, 'h87, "R8 held");
    wr(8'hDC, 8'h7F); rd(16'hFEDC, 'h07, "R8 cleared");
    tk(); rd(16'hFEDC, 'h87, "R8 late set");
    // R7 write plus tick same cycle: no decrement
    wr(8'hDC, 8'h7F);
    cyc_drv(1, 8'hDB, 8'h22, 1, 0, 0);
    tk(); rd(16'hFEDC, 'h07, "R7 reload");
    tk(); rd(16'hFEDC, 'h87, "R7 expiry");
    // R10 / R11
    rx(8'h5A); rd(16'hFEDD, 'h5A, "R10 rdr"); rd(16'hFEDC, 'hC7, "R10 rdrf");
    rx(8'h6B); rd(16'hFEDC, 'hE7, "R11 overrun");
    wr(8'hDC, 8'h07); rd(16'hFEDC, 'h07, "R5 all clear");
    wr(8'hDC, 8'hFF); rd(16'hFEDC, 'h07, "R5 ones no set");
    // R12 rx vs clearing write
    rx(8'h01); rd(16'hFEDC, 'h47, "R10 rdrf2");
    cyc_drv(1, 8'hDC, 8'h07, 0, 1, 8'h02);
    rd(16'hFEDC, 'h47, "R12 rx wins no ovr");
    rd(16'hFEDD, 'h02, "R12 rdr");
    // R12 tick expiry vs clearing write
    wr(8'hDB, 8'h44); tk(); tk();
    rd(16'hFEDC, 'hC7, "R8 set");
    wr(8'hDB, 8'h45); tk(); tk();
    rd(16'hFEDC, 'hC7, "R8 held2");
    cyc_drv(1, 8'hDC, 8'h7F, 1, 0, 0);
    rd(16'hFEDC, 'hC7, "R12 tick wins");
    wr(8'hDC, 8'h7F); tk();
    rd(16'hFEDC, 'h47, "R12 pending spent");
    // R10 bus rdr write vs rx
    cyc_drv(1, 8'hDD, 8'h99, 0, 1, 8'h77);
    rd(16'hFEDD, 'h77, "R10 rx over bus");
    wr(8'hDD, 8'h99); rd(16'hFEDD, 'h99, "R10 bus rdr");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule